// File: doc/BRIEF.md
# Eight-Pin Interrupt Event Detector

This block watches the already-synchronized inputs of one eight-pin port and turns selected activity on them into a single interrupt line for the port. Software gives each pin its own trigger type. The choices are a rising edge, a falling edge, either edge, a high level or a low level. Every detected event sets a sticky per-pin status bit. A per-pin enable decides which status bits reach the combined interrupt output. Software acknowledges events by writing ones to a clear register.

All configuration goes through a simple write port: a strobe, a byte address and 32 bits of data, taking effect at the clock edge. Reads are combinational from a separate read address. The status, enable and trigger registers each have a second, masked address. A write there changes only the pins picked by a mask field, so software can change one pin without a read-modify-write. Events always take priority over any software action that would lower a status bit in the same cycle, so no edge is lost.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is held, status, enable and the trigger register all read as zero and `irq_out` is low.
- R2: The trigger register at 0x60 holds three bits per pin n. Bit n is the polarity (1 = high or rising). Bit 8+n selects edge mode (1) or level mode (0). Bit 16+n selects both edges. It reads back with bits 31:24 as zero. With the reset value every pin is in low-level mode.
- R3: In level mode the status bit of pin n is set on every clock edge where the pin matches the polarity. This also happens in the cycle right after a clear, so a clear has no lasting effect while the level holds.
- R4: In edge mode with the both bit clear, a pin sets its status bit when its value differs from the registered value of the previous cycle in the direction given by the polarity: 0 to 1 for rising, 1 to 0 for falling.
- R5: In edge mode with the both bit set, a pin sets its status bit on any change, whatever the polarity. In level mode the both bit has no effect.
- R6: Status bits stay set until software clears them. A write to the status address 0x40 leaves the status unchanged.
- R7: Writing to 0x70 clears status bit n for each data bit n that is 1. Data bits that are 0 leave their status bits as they are. The address reads as zero.
- R8: When a pin detects an event in the same cycle as a write that would clear its status bit, the bit is left set.
- R9: `irq_out` is high exactly when some pin has both its status bit and its enable bit (register 0x50, bit n) set. It follows the registers with no further delay.
- R10: A write to 0xD0 uses bits 15:8 as a pin mask and bits 7:0 as new enable values. Only masked pins change. Reading 0xD0 returns the enable register.
- R11: A write to 0xC0 uses the same mask and value format to set or clear status bits of the masked pins. Other pins keep their status. Events still take priority, as in R8.
- R12: A write to 0xE0 uses bits 31:24 as a pin mask. For each masked pin n, bits n, 8+n and 16+n of the data replace that pin's three trigger bits. The new trigger type takes effect from the next clock edge. Reading 0xE0 returns the trigger register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | NPIN | Synchronized pin levels |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Byte address of the read |
| rd_data | output | DW | Combinational read data, zero for unmapped addresses |
| irq_out | output | 1 | Combined port interrupt |

## Verification
Two situations are hard to reach from the ports. The first is a fresh edge landing in the very cycle a clear write hits the same pin. The bench reaches it by driving the pin transition and the clear write on the same falling clock edge, so that one rising edge registers both. The second is a level that re-asserts right after it is acknowledged. The bench holds the pin active across a clear and then drops it together with a second clear. Because the reset trigger value makes every pin low-level sensitive, the bench idles the pins high. It also expects the one pin that is idle low to be latched before it is configured.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Byte offsets inside the port window; software decodes these.
    localparam logic [7:0] OFS_STA   = 8'h40;
    localparam logic [7:0] OFS_ENA   = 8'h50;
    localparam logic [7:0] OFS_TRG   = 8'h60;
    localparam logic [7:0] OFS_CLR   = 8'h70;
    localparam logic [7:0] OFS_MSTA  = 8'hC0;
    localparam logic [7:0] OFS_MENA  = 8'hD0;
    localparam logic [7:0] OFS_MTRG  = 8'hE0;

    // Lane spacing of the per-pin fields in the data word.
    localparam int LANE_W = 8;

    typedef enum logic [2:0] {
        TRIG_LVL_LO = 3'd0,
        TRIG_LVL_HI = 3'd1,
        TRIG_RISE   = 3'd2,
        TRIG_FALL   = 3'd3,
        TRIG_BOTH   = 3'd4
    } trig_e;

    // Map the three stored bits of one pin onto a trigger kind.
    function automatic trig_e decode_trig(input logic pol, input logic edg, input logic both);
        trig_e k;
        if (!edg) begin
            k = pol ? TRIG_LVL_HI : TRIG_LVL_LO;
        end else if (both) begin
            k = TRIG_BOTH;
        end else begin
            k = pol ? TRIG_RISE : TRIG_FALL;
        end
        return k;
    endfunction

endpackage

// File: rtl/gpio_irq_pin_det.sv
module gpio_irq_pin_det
    import gpio_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin_i,
    input  trig_e trig_i,
    output logic  hit_o
);

    logic prev_q;

    // Previous-cycle copy of the pin, kept in every mode so a
    // change of trigger type never sees a stale sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= pin_i;
        end
    end

    always_comb begin
        hit_o = 1'b0;
        unique case (trig_i)
            TRIG_LVL_LO: hit_o = ~pin_i;
            TRIG_LVL_HI: hit_o = pin_i;
            TRIG_RISE:   hit_o = pin_i & ~prev_q;
            TRIG_FALL:   hit_o = ~pin_i & prev_q;
            TRIG_BOTH:   hit_o = pin_i ^ prev_q;
            default:     hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_regfile.sv
module gpio_irq_regfile
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 8,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [NPIN-1:0] hit_i,
    output logic [NPIN-1:0] sta_o,
    output logic [NPIN-1:0] ena_o,
    output logic [NPIN-1:0] pol_o,
    output logic [NPIN-1:0] edg_o,
    output logic [NPIN-1:0] both_o
);

    localparam int TRG_MASK_LSB = 3 * LANE_W;

    logic [NPIN-1:0] sta_q, ena_q, pol_q, edg_q, both_q;
    logic [NPIN-1:0] sta_d, ena_d, pol_d, edg_d, both_d;
    logic [NPIN-1:0] clr_bits, swr_mask, swr_val;

    logic [NPIN-1:0] f_lane0, f_lane1, f_lane2, f_bmask, f_tmask;
    logic [AW-1:0]   a_sta, a_ena, a_trg, a_clr, a_msta, a_mena, a_mtrg;

    assign f_lane0 = wr_data[0 +: NPIN];
    assign f_lane1 = wr_data[LANE_W +: NPIN];
    assign f_lane2 = wr_data[2*LANE_W +: NPIN];
    assign f_bmask = wr_data[LANE_W +: NPIN];
    assign f_tmask = wr_data[TRG_MASK_LSB +: NPIN];

    assign a_sta  = AW'(OFS_STA);
    assign a_ena  = AW'(OFS_ENA);
    assign a_trg  = AW'(OFS_TRG);
    assign a_clr  = AW'(OFS_CLR);
    assign a_msta = AW'(OFS_MSTA);
    assign a_mena = AW'(OFS_MENA);
    assign a_mtrg = AW'(OFS_MTRG);

    // Write decode: one register touched per write.
    always_comb begin
        ena_d    = ena_q;
        pol_d    = pol_q;
        edg_d    = edg_q;
        both_d   = both_q;
        clr_bits = '0;
        swr_mask = '0;
        swr_val  = '0;
        if (wr_en) begin
            if (wr_addr == a_ena) begin
                ena_d = f_lane0;
            end else if (wr_addr == a_mena) begin
                ena_d = (ena_q & ~f_bmask) | (f_lane0 & f_bmask);
            end else if (wr_addr == a_trg) begin
                pol_d  = f_lane0;
                edg_d  = f_lane1;
                both_d = f_lane2;
            end else if (wr_addr == a_mtrg) begin
                pol_d  = (pol_q  & ~f_tmask) | (f_lane0 & f_tmask);
                edg_d  = (edg_q  & ~f_tmask) | (f_lane1 & f_tmask);
                both_d = (both_q & ~f_tmask) | (f_lane2 & f_tmask);
            end else if (wr_addr == a_clr) begin
                clr_bits = f_lane0;
            end else if (wr_addr == a_msta) begin
                swr_mask = f_bmask;
                swr_val  = f_lane0;
            end else if (wr_addr == a_sta) begin
                // status is not directly writable
                clr_bits = '0;
            end
        end
    end

    // Status: software action first, detected events override it.
    always_comb begin
        sta_d = sta_q & ~clr_bits;
        sta_d = (sta_d & ~swr_mask) | (swr_val & swr_mask);
        sta_d = sta_d | hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sta_q  <= '0;
            ena_q  <= '0;
            pol_q  <= '0;
            edg_q  <= '0;
            both_q <= '0;
        end else begin
            sta_q  <= sta_d;
            ena_q  <= ena_d;
            pol_q  <= pol_d;
            edg_q  <= edg_d;
            both_q <= both_d;
        end
    end

    assign sta_o  = sta_q;
    assign ena_o  = ena_q;
    assign pol_o  = pol_q;
    assign edg_o  = edg_q;
    assign both_o = both_q;

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 8,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pins_in,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic            irq_out
);

    logic [NPIN-1:0] hit;
    logic [NPIN-1:0] sta_q, ena_q, pol_q, edg_q, both_q;

    gpio_irq_regfile #(
        .NPIN (NPIN),
        .AW   (AW),
        .DW   (DW)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .hit_i   (hit),
        .sta_o   (sta_q),
        .ena_o   (ena_q),
        .pol_o   (pol_q),
        .edg_o   (edg_q),
        .both_o  (both_q)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        trig_e trig_w;
        assign trig_w = decode_trig(pol_q[g], edg_q[g], both_q[g]);

        gpio_irq_pin_det u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pins_in[g]),
            .trig_i (trig_w),
            .hit_o  (hit[g])
        );
    end

    assign irq_out = |(sta_q & ena_q);

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(OFS_STA) || rd_addr == AW'(OFS_MSTA)) begin
            rd_data[0 +: NPIN] = sta_q;
        end else if (rd_addr == AW'(OFS_ENA) || rd_addr == AW'(OFS_MENA)) begin
            rd_data[0 +: NPIN] = ena_q;
        end else if (rd_addr == AW'(OFS_TRG) || rd_addr == AW'(OFS_MTRG)) begin
            rd_data[0 +: NPIN]        = pol_q;
            rd_data[LANE_W +: NPIN]   = edg_q;
            rd_data[2*LANE_W +: NPIN] = both_q;
        end
    end

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 8,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NPIN-1:0] pins_in,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic [DW-1:0]   wr_data,
    input logic            irq_out,
    input logic [NPIN-1:0] sta_q,
    input logic [NPIN-1:0] ena_q,
    input logic [NPIN-1:0] pol_q,
    input logic [NPIN-1:0] edg_q,
    input logic [NPIN-1:0] both_q
);

    logic [NPIN-1:0] lvl_act;
    logic [NPIN-1:0] d_low;
    logic [NPIN-1:0] d_bmask;
    logic [NPIN-1:0] d_tmask;
    logic            w_clr, w_msta, w_mena, w_mtrg;

    assign lvl_act = ~edg_q & ~(pins_in ^ pol_q);
    assign d_low   = wr_data[0 +: NPIN];
    assign d_bmask = wr_data[LANE_W +: NPIN];
    assign d_tmask = wr_data[3*LANE_W +: NPIN];
    assign w_clr   = wr_en && (wr_addr == AW'(OFS_CLR));
    assign w_msta  = wr_en && (wr_addr == AW'(OFS_MSTA));
    assign w_mena  = wr_en && (wr_addr == AW'(OFS_MENA));
    assign w_mtrg  = wr_en && (wr_addr == AW'(OFS_MTRG));

    // R3: an active level is latched on the next edge, clear or not
    a_r3_level_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_act != '0) |=> ((sta_q & $past(lvl_act)) == $past(lvl_act)));

    // R6: without a clear or a masked status write no bit falls
    a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(w_clr || w_msta) |=> ((sta_q & $past(sta_q)) == $past(sta_q)));

    // R7: a clear leaves the bits written as zero untouched
    a_r7_zero_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        w_clr |=> ((sta_q & $past(sta_q & ~d_low)) == $past(sta_q & ~d_low)));

    // R9: the combined line needs an enabled pin and a pending status
    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((ena_q != '0) && (sta_q != '0)));

    // R10: masked enable write keeps unmasked pins
    a_r10_enable_mask: assert property (@(posedge clk) disable iff (!rst_n)
        w_mena |=> (((ena_q ^ $past(ena_q)) & ~$past(d_bmask)) == '0));

    // R12: masked trigger write keeps unmasked pins in all three lanes
    a_r12_trigger_mask: assert property (@(posedge clk) disable iff (!rst_n)
        w_mtrg |=> ((((pol_q ^ $past(pol_q)) | (edg_q ^ $past(edg_q)) |
                      (both_q ^ $past(both_q))) & ~$past(d_tmask)) == '0));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(
    .NPIN (NPIN),
    .AW   (AW),
    .DW   (DW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins_in (pins_in),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .irq_out (irq_out),
    .sta_q   (sta_q),
    .ena_q   (ena_q),
    .pol_q   (pol_q),
    .edg_q   (edg_q),
    .both_q  (both_q)
);

// File: tb/gpio_irq_port_test.sv
`timescale 1ns/1ps
module gpio_irq_port_test;

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [7:0]  pins;
        logic [7:0]  sta;
        logic        irq;
        logic [7:0]  req;
    } step_t;

    // Pins idle at 0xF7. Pin0 rising, pin1 falling, pin2 both,
    // pin3 level high, pins 4..7 level low.
    localparam step_t STEPS [22] = '{
        '{1'b1, 8'h60, 32'h0004_0709, 8'hF7, 8'h08, 1'b0, 8'd2 },  // R2 (pin3 latched under reset type)
        '{1'b1, 8'h70, 32'h0000_00FF, 8'hF7, 8'h00, 1'b0, 8'd7 },  // R7
        '{1'b1, 8'h50, 32'h0000_0001, 8'hF7, 8'h00, 1'b0, 8'd9 },  // R9
        '{1'b0, 8'h00, 32'h0,         8'hF6, 8'h00, 1'b0, 8'd4 },  // R4 fall on rising pin
        '{1'b0, 8'h00, 32'h0,         8'hF7, 8'h01, 1'b1, 8'd4 },  // R4 rise
        '{1'b0, 8'h00, 32'h0,         8'hF7, 8'h01, 1'b1, 8'd6 },  // R6 sticky
        '{1'b0, 8'h00, 32'h0,         8'hF5, 8'h03, 1'b1, 8'd4 },  // R4 falling pin1
        '{1'b1, 8'h70, 32'h0000_0001, 8'hF5, 8'h02, 1'b0, 8'd7 },  // R7
        '{1'b1, 8'h40, 32'h0000_0000, 8'hF5, 8'h02, 1'b0, 8'd6 },  // R6 direct write ignored
        '{1'b0, 8'h00, 32'h0,         8'hF1, 8'h06, 1'b0, 8'd5 },  // R5 both, falling
        '{1'b1, 8'h70, 32'h0000_0004, 8'hF5, 8'h06, 1'b0, 8'd8 },  // R8 edge beats clear
        '{1'b0, 8'h00, 32'h0,         8'hFD, 8'h0E, 1'b0, 8'd3 },  // R3 level high
        '{1'b1, 8'h70, 32'h0000_0008, 8'hFD, 8'h0E, 1'b0, 8'd3 },  // R3 re-set after clear
        '{1'b1, 8'h70, 32'h0000_0008, 8'hF5, 8'h06, 1'b0, 8'd7 },  // R7
        '{1'b0, 8'h00, 32'h0,         8'hE5, 8'h16, 1'b0, 8'd3 },  // R3 level low
        '{1'b1, 8'hD0, 32'h0000_1010, 8'hE5, 8'h16, 1'b1, 8'd10},  // R10
        '{1'b1, 8'hD0, 32'h0000_0100, 8'hE5, 8'h16, 1'b1, 8'd10},  // R10
        '{1'b1, 8'hC0, 32'h0000_8080, 8'hF5, 8'h96, 1'b1, 8'd11},  // R11 set
        '{1'b1, 8'hC0, 32'h0000_1200, 8'hF5, 8'h84, 1'b0, 8'd11},  // R11 clear
        '{1'b1, 8'hE0, 32'h1000_1010, 8'hF5, 8'h84, 1'b0, 8'd12},  // R12
        '{1'b0, 8'h00, 32'h0,         8'hE5, 8'h84, 1'b0, 8'd12},  // R12 pin4 now rising
        '{1'b0, 8'h00, 32'h0,         8'hF5, 8'h94, 1'b1, 8'd12}   // R12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pins_in = 8'hF7;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = 8'h40;
    logic [31:0] rd_data;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_port uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_in (pins_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq_out (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        read_chk("R1 status in reset", 8'h40, 32'h0);
        read_chk("R1 enable in reset", 8'h50, 32'h0);
        read_chk("R1 trigger in reset", 8'h60, 32'h0);
        check("R1 irq in reset", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 22; i++) begin
            wr_en   = STEPS[i].we;
            wr_addr = STEPS[i].addr;
            wr_data = STEPS[i].data;
            pins_in = STEPS[i].pins;
            rd_addr = 8'h40;
            @(negedge clk);
            check($sformatf("R%0d step %0d status", STEPS[i].req, i),
                  rd_data, {24'b0, STEPS[i].sta});
            check($sformatf("R%0d step %0d irq", STEPS[i].req, i),
                  {31'b0, irq_out}, {31'b0, STEPS[i].irq});
        end
        wr_en = 1'b0;

        // R2 / R12: trigger layout and masked-alias read
        read_chk("R2 trigger readback", 8'h60, 32'h0004_1719);
        read_chk("R12 trigger alias readback", 8'hE0, 32'h0004_1719);
        // R10: enable and alias readback
        read_chk("R10 enable readback", 8'h50, 32'h0000_0010);
        read_chk("R10 enable alias readback", 8'hD0, 32'h0000_0010);
        // R7: clear address reads zero; unmapped read zero
        read_chk("R7 clear reads zero", 8'h70, 32'h0);
        read_chk("R7 unmapped reads zero", 8'h44, 32'h0);
        // R11: status alias reads status
        read_chk("R11 status alias readback", 8'hC0, 32'h0000_0094);

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        read_chk("R1 status after reset", 8'h40, 32'h0);
        read_chk("R1 enable after reset", 8'h50, 32'h0);
        read_chk("R1 trigger after reset", 8'h60, 32'h0);
        check("R1 irq after reset", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule